// File: doc/BRIEF.md
# H-Bridge Command Decoder with Fault Latch

This block is the digital control core for one H-bridge of a brushed DC motor driver. Two polarity inputs, one per half-bridge leg, select which switch of each leg conducts. An active-high disable input turns the whole bridge off and pulls the active-low status flag down. An active-low enable input puts the bridge to sleep. Digital flags from the analog side report undervoltage, overtemperature, a temperature-cooled-below-release condition, and short-circuit. A force-off request from the current regulator also enters here. The block produces a high-side and a low-side gate command for each leg, the status flag and a sleep indication.

Every asynchronous input passes through a two-flop synchronizer. The reset values of the synchronizer stand for the state an undriven pin settles to: disabled, asleep, polarity high. A mode state machine resolves the inputs by priority. Its states are SLEEP, HOLD (disabled), RUN, UVLO, LATCH and COOL. Its transitions are wake (SLEEP to any awake state), doze (any state to SLEEP on enable low), trip (to LATCH on short or overtemperature), release (LATCH to an awake state on a clearing edge), cool-done (COOL onward once the cooled flag is high), and the plain moves among HOLD, RUN and UVLO. Each leg has its own small state machine with the states OFF, HI and LO. It adds a dead time whenever the leg turns on, so the two switches of a leg never conduct together.

Top module: `hb_cmd_top`

## Requirements
- R1: After reset, with inputs at their undriven defaults (disable 1, enable 0, polarities 1), sleep_o is 1, sf_n_o is 1 and all four gate commands are 0.
- R2: In RUN, each leg i follows its polarity input: polarity 1 drives hs_o[i]=1, ls_o[i]=0; polarity 0 drives hs_o[i]=0, ls_o[i]=1. This covers the patterns (1,0), (0,1), (0,0) and (1,1). Leg A is index 0, leg B is index 1.
- R3: While disable is 1 and enable is 1, with no fault, all gates are 0 and sf_n_o is 0, whatever the polarity inputs are.
- R4: While enable is 0, sleep_o is 1, sf_n_o is 1 and all gates are 0. Enable low takes priority over every other input.
- R5: Undervoltage forces all gates to 0 and sf_n_o to 0. When the flag drops, the bridge returns to the commanded state with no other action.
- R6: A short-circuit or overtemperature flag seen while enabled latches all gates to 0 and sf_n_o to 0. The latch holds after the flag drops.
- R7: The latch clears only on a 1-to-0 transition of disable, on a 0-to-1 transition of enable, or on reset. A 0-to-1 transition of disable does not clear it. If the fault is still present at the clearing edge, the block latches again.
- R8: After an overtemperature trip, a cleared latch leads to COOL (gates 0, sf_n_o 0) until the cooled flag reads 1. If the cooled flag was already seen at 1 after the trip, the release goes straight on.
- R9: force_off_i turns off all gates and leaves sf_n_o unchanged.
- R10: A leg turns a switch on only after exactly DEAD_CYC consecutive cycles with both of its switches off. hs_o[i] and ls_o[i] are never 1 together.
- R11: An input change made between rising edges reaches sf_n_o and sleep_o on the third rising edge. It reaches a gate turn-off on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pol_a_i | input | 1 | Polarity command, leg A (1 = high side) |
| pol_b_i | input | 1 | Polarity command, leg B (1 = high side) |
| dis_i | input | 1 | Active-high bridge disable |
| en_i | input | 1 | Active-high enable, low = sleep |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Overtemperature shutdown flag |
| cool_i | input | 1 | Temperature is below the shutdown threshold minus hysteresis |
| sc_i | input | 1 | Short-circuit detected |
| force_off_i | input | 1 | Off request from the current regulator |
| hs_o | output | 2 | High-side gate commands, [0] = leg A |
| ls_o | output | 2 | Low-side gate commands, [0] = leg A |
| sf_n_o | output | 1 | Active-low status flag |
| sleep_o | output | 1 | Bridge is asleep |

## Verification
The bench drives its inputs just after a falling edge. The status and sleep outputs respond on the third rising edge that follows, and the gate commands on the fourth. A turn-on is then delayed by DEAD_CYC more cycles. A behavioural model shifts the input history through a queue by those same edge counts, and the bench compares every output against it at each falling edge. Direct checks probe the exact edge on which the status flag falls after a disable. They also count the off cycles during a leg reversal, and confirm that a rising disable edge does not release a latch while a falling one does.

// File: rtl/hb_cmd_pkg.sv
package hb_cmd_pkg;

    localparam int HB_LEGS   = 2;
    localparam int HB_NUM_IN = 9;

    // bit positions inside the synchronized input word
    localparam int IX_POL_A = 0;
    localparam int IX_POL_B = 1;
    localparam int IX_DIS   = 2;
    localparam int IX_EN    = 3;
    localparam int IX_UV    = 4;
    localparam int IX_OT    = 5;
    localparam int IX_COOL  = 6;
    localparam int IX_SC    = 7;
    localparam int IX_FOFF  = 8;

    // undriven pin levels: polarities high, disabled, asleep, cooled
    localparam logic [HB_NUM_IN-1:0] HB_IN_DEFAULT = 9'b0_0_1_0_0_0_1_1_1;

    typedef enum logic [2:0] {
        FS_SLEEP = 3'd0,
        FS_HOLD  = 3'd1,
        FS_RUN   = 3'd2,
        FS_UVLO  = 3'd3,
        FS_LATCH = 3'd4,
        FS_COOL  = 3'd5
    } hb_mode_e;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } hb_leg_e;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            stable_q <= RST_VAL;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/hb_mode_fsm.sv
module hb_mode_fsm
    import hb_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_dis,
    input  logic s_en,
    input  logic s_uv,
    input  logic s_ot,
    input  logic s_cool,
    input  logic s_sc,
    output logic run_o,
    output logic sf_n_o,
    output logic sleep_o
);

    hb_mode_e state_q, state_n;
    hb_mode_e settle;
    logic     prev_dis_q, prev_en_q;
    logic     trip_q, trip_n;
    logic     dis_fall, en_rise, clr;

    assign dis_fall = prev_dis_q & ~s_dis;
    assign en_rise  = ~prev_en_q & s_en;
    assign clr      = dis_fall | en_rise;

    // destination for an awake bridge that is not held in the latch
    always_comb begin
        if (s_sc || s_ot)
            settle = FS_LATCH;
        else if (trip_q && !s_cool)
            settle = FS_COOL;
        else if (s_uv)
            settle = FS_UVLO;
        else if (s_dis)
            settle = FS_HOLD;
        else
            settle = FS_RUN;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FS_SLEEP: if (s_en) state_n = settle;          // wake
            FS_LATCH: begin
                if (!s_en)     state_n = FS_SLEEP;         // doze
                else if (clr)  state_n = settle;           // release
            end
            FS_HOLD, FS_RUN, FS_UVLO, FS_COOL: begin
                if (!s_en)     state_n = FS_SLEEP;         // doze
                else           state_n = settle;           // trip, cool-done, moves
            end
            default:           state_n = FS_SLEEP;
        endcase
    end

    always_comb begin
        if (state_n == FS_LATCH && s_ot)
            trip_n = 1'b1;
        else if (s_cool)
            trip_n = 1'b0;
        else
            trip_n = trip_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FS_SLEEP;
            trip_q     <= 1'b0;
            prev_dis_q <= HB_IN_DEFAULT[IX_DIS];
            prev_en_q  <= HB_IN_DEFAULT[IX_EN];
        end else begin
            state_q    <= state_n;
            trip_q     <= trip_n;
            prev_dis_q <= s_dis;
            prev_en_q  <= s_en;
        end
    end

    always_comb begin
        run_o   = 1'b0;
        sf_n_o  = 1'b1;
        sleep_o = 1'b0;
        unique case (state_q)
            FS_SLEEP: sleep_o = 1'b1;
            FS_RUN:   run_o   = 1'b1;
            FS_HOLD,
            FS_UVLO,
            FS_LATCH,
            FS_COOL:  sf_n_o  = 1'b0;
            default:  sleep_o = 1'b1;
        endcase
    end

    AST_DIS_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        s_dis |=> (state_q != FS_RUN)); // R3

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_LATCH && s_en && !clr) |=> (state_q == FS_LATCH)); // R7

    AST_UV_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_uv && s_en) |=> (state_q != FS_RUN)); // R5

endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_cmd_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic pol,
    output logic hs_o,
    output logic ls_o
);

    localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP_MAX = CW'(DEAD_CYC);

    hb_leg_e       side_q, side_n, tgt;
    logic [CW-1:0] off_cnt_q, off_cnt_n;
    logic          gap_done;

    assign gap_done = (off_cnt_q >= GAP_MAX);

    always_comb begin
        if (!drive_en)
            tgt = LEG_OFF;
        else if (pol)
            tgt = LEG_HI;
        else
            tgt = LEG_LO;
    end

    always_comb begin
        side_n = LEG_OFF;
        unique case (side_q)
            LEG_OFF: if (tgt != LEG_OFF && gap_done) side_n = tgt;
            LEG_HI:  if (tgt == LEG_HI)              side_n = LEG_HI;
            LEG_LO:  if (tgt == LEG_LO)              side_n = LEG_LO;
            default:                                 side_n = LEG_OFF;
        endcase
    end

    always_comb begin
        if (side_n != LEG_OFF)
            off_cnt_n = '0;
        else if (off_cnt_q != GAP_MAX)
            off_cnt_n = off_cnt_q + 1'b1;
        else
            off_cnt_n = off_cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            side_q    <= LEG_OFF;
            off_cnt_q <= '0;
        end else begin
            side_q    <= side_n;
            off_cnt_q <= off_cnt_n;
        end
    end

    always_comb begin
        hs_o = (side_q == LEG_HI);
        ls_o = (side_q == LEG_LO);
    end

    AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o)); // R10

    AST_ON_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (side_q != LEG_OFF && side_q != $past(side_q)) |-> ($past(side_q) == LEG_OFF)); // R10

endmodule

// File: rtl/hb_cmd_top.sv
module hb_cmd_top
    import hb_cmd_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pol_a_i,
    input  logic               pol_b_i,
    input  logic               dis_i,
    input  logic               en_i,
    input  logic               uv_i,
    input  logic               ot_i,
    input  logic               cool_i,
    input  logic               sc_i,
    input  logic               force_off_i,
    output logic [HB_LEGS-1:0] hs_o,
    output logic [HB_LEGS-1:0] ls_o,
    output logic               sf_n_o,
    output logic               sleep_o
);

    logic [HB_NUM_IN-1:0] raw_in, s_in;
    logic [HB_LEGS-1:0]   s_pol;
    logic                 run, drive_en;

    always_comb begin
        raw_in           = '0;
        raw_in[IX_POL_A] = pol_a_i;
        raw_in[IX_POL_B] = pol_b_i;
        raw_in[IX_DIS]   = dis_i;
        raw_in[IX_EN]    = en_i;
        raw_in[IX_UV]    = uv_i;
        raw_in[IX_OT]    = ot_i;
        raw_in[IX_COOL]  = cool_i;
        raw_in[IX_SC]    = sc_i;
        raw_in[IX_FOFF]  = force_off_i;
    end

    hb_sync #(
        .W       (HB_NUM_IN),
        .RST_VAL (HB_IN_DEFAULT)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (s_in)
    );

    hb_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_dis   (s_in[IX_DIS]),
        .s_en    (s_in[IX_EN]),
        .s_uv    (s_in[IX_UV]),
        .s_ot    (s_in[IX_OT]),
        .s_cool  (s_in[IX_COOL]),
        .s_sc    (s_in[IX_SC]),
        .run_o   (run),
        .sf_n_o  (sf_n_o),
        .sleep_o (sleep_o)
    );

    assign drive_en = run & ~s_in[IX_FOFF];
    assign s_pol    = {s_in[IX_POL_B], s_in[IX_POL_A]};

    for (genvar g = 0; g < HB_LEGS; g++) begin : g_leg
        hb_leg #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .drive_en (drive_en),
            .pol      (s_pol[g]),
            .hs_o     (hs_o[g]),
            .ls_o     (ls_o[g])
        );
    end

    AST_FORCE_OFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        s_in[IX_FOFF] |=> (hs_o == '0 && ls_o == '0)); // R9

    AST_SLEEP_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !s_in[IX_EN] |=> (sleep_o && sf_n_o)); // R4

endmodule

// File: tb/hb_cmd_top_test.sv
module hb_cmd_top_test;

    localparam int DEAD = 4;
    localparam logic [8:0] DEF = 9'b0_0_1_0_0_0_1_1_1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pol_a_i = 1'b1, pol_b_i = 1'b1, dis_i = 1'b1, en_i = 1'b0;
    logic uv_i = 1'b0, ot_i = 1'b0, cool_i = 1'b1, sc_i = 1'b0, force_off_i = 1'b0;
    logic [1:0] hs_o, ls_o;
    logic sf_n_o, sleep_o;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    hb_cmd_top #(.DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst_n(rst_n),
        .pol_a_i(pol_a_i), .pol_b_i(pol_b_i), .dis_i(dis_i), .en_i(en_i),
        .uv_i(uv_i), .ot_i(ot_i), .cool_i(cool_i), .sc_i(sc_i),
        .force_off_i(force_off_i),
        .hs_o(hs_o), .ls_o(ls_o), .sf_n_o(sf_n_o), .sleep_o(sleep_o)
    );

    // ---------------- behavioural reference model ----------------
    // model modes: 0 sleep, 1 disabled, 2 run, 3 undervoltage, 4 latched, 5 cooling
    logic [8:0] hist[$];
    logic [8:0] s, p;
    int m_mode, m_trip, nmode, settle, tgt, nside;
    int m_side[2];
    int m_off[2];
    bit drv, clr;

    function automatic logic [8:0] in_word();
        return {force_off_i, sc_i, cool_i, ot_i, uv_i, en_i, dis_i, pol_b_i, pol_a_i};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = {DEF, DEF, DEF, DEF};
            m_mode = 0; m_trip = 0;
            m_side[0] = 0; m_side[1] = 0;
            m_off[0] = 0;  m_off[1] = 0;
        end else begin
            hist.push_back(in_word());
            s = hist[2];       // two edges of synchronizer delay
            p = hist[1];       // one more for edge detection
            void'(hist.pop_front());
            drv = (m_mode == 2) && !s[8];
            for (int i = 0; i < 2; i++) begin
                tgt = !drv ? 0 : (s[i] ? 1 : 2);
                if (tgt == 0) nside = 0;
                else if (m_side[i] == tgt) nside = tgt;
                else if (m_side[i] == 0 && m_off[i] >= DEAD) nside = tgt;
                else nside = 0;
                if (nside == 0) m_off[i] = (m_off[i] < DEAD) ? m_off[i] + 1 : DEAD;
                else m_off[i] = 0;
                m_side[i] = nside;
            end
            if (s[7] || s[5]) settle = 4;
            else if (m_trip != 0 && !s[6]) settle = 5;
            else if (s[4]) settle = 3;
            else if (s[2]) settle = 1;
            else settle = 2;
            clr = (p[2] && !s[2]) || (!p[3] && s[3]);
            if (!s[3]) nmode = 0;
            else if (m_mode == 4 && !clr) nmode = 4;
            else nmode = settle;
            if (nmode == 4 && s[5]) m_trip = 1;
            else if (s[6]) m_trip = 0;
            m_mode = nmode;
        end
    end

    function automatic logic [5:0] model_out();
        logic [1:0] eh, el;
        for (int i = 0; i < 2; i++) begin
            eh[i] = (m_side[i] == 1);
            el[i] = (m_side[i] == 2);
        end
        return {eh, el, (m_mode == 0 || m_mode == 2), (m_mode == 0)};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({hs_o, ls_o, sf_n_o, sleep_o} !== model_out()) begin
                fails++;
                $display("FAIL %s cycle-compare: got hs=%b ls=%b sf_n=%b sleep=%b expected %b",
                         cur_req, hs_o, ls_o, sf_n_o, sleep_o, model_out());
            end
        end
    end

    // ---------------- direct checks ----------------
    task automatic chk(input string tag, input logic [5:0] exp);
        checks++;
        if ({hs_o, ls_o, sf_n_o, sleep_o} !== exp) begin
            fails++;
            $display("FAIL %s: got hs=%b ls=%b sf_n=%b sleep=%b expected %b",
                     tag, hs_o, ls_o, sf_n_o, sleep_o, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam int SETTLE = DEAD + 10;
    localparam logic [5:0] O_FWD   = 6'b01_10_1_0;
    localparam logic [5:0] O_REV   = 6'b10_01_1_0;
    localparam logic [5:0] O_LOWFW = 6'b00_11_1_0;
    localparam logic [5:0] O_HIFW  = 6'b11_00_1_0;
    localparam logic [5:0] O_FLAG  = 6'b00_00_0_0;
    localparam logic [5:0] O_SLEEP = 6'b00_00_1_1;
    localparam logic [5:0] O_QUIET = 6'b00_00_1_0;

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        cyc(4);
        rst_n = 1'b1;
        cyc(SETTLE);
        cur_req = "R1";
        chk("R1 reset defaults", O_SLEEP);

        cur_req = "R2";
        en_i = 1; dis_i = 0; cyc(SETTLE);
        chk("R2 high freewheel (1,1)", O_HIFW);
        pol_b_i = 0; cyc(SETTLE);
        chk("R2 forward (1,0)", O_FWD);
        pol_a_i = 0; pol_b_i = 1; cyc(SETTLE);
        chk("R2 reverse (0,1)", O_REV);
        pol_b_i = 0; cyc(SETTLE);
        chk("R2 low freewheel (0,0)", O_LOWFW);

        cur_req = "R10";
        pol_a_i = 1; cyc(SETTLE);
        pol_a_i = 0; n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!hs_o[0] && !ls_o[0]) n++;
            if (ls_o[0]) break;
        end
        chk_int("R10 dead cycles leg A", n, DEAD);

        cur_req = "R11";
        pol_a_i = 0; pol_b_i = 1; cyc(SETTLE);
        dis_i = 1;
        cyc(2); chk("R11 flag not yet at edge 2", O_REV);
        cyc(1); chk("R11 flag at edge 3, gates still on", {4'b10_01, 2'b00});
        cyc(1); chk("R11 gates off at edge 4", O_FLAG);

        cur_req = "R3";
        pol_a_i = 1; pol_b_i = 0; cyc(SETTLE);
        chk("R3 disable ignores polarity", O_FLAG);
        dis_i = 0; cyc(SETTLE);
        chk("R3 release disable", O_FWD);

        cur_req = "R4";
        en_i = 0; dis_i = 1; uv_i = 1; cyc(SETTLE);
        chk("R4 sleep has priority", O_SLEEP);
        en_i = 1; dis_i = 0; uv_i = 0; cyc(SETTLE);
        chk("R4 wake", O_FWD);

        cur_req = "R5";
        uv_i = 1; cyc(SETTLE);
        chk("R5 undervoltage off", O_FLAG);
        uv_i = 0; cyc(SETTLE);
        chk("R5 auto recovery", O_FWD);

        cur_req = "R9";
        force_off_i = 1; cyc(SETTLE);
        chk("R9 force off, flag high", O_QUIET);
        force_off_i = 0; cyc(SETTLE);
        chk("R9 force off released", O_FWD);

        cur_req = "R6";
        sc_i = 1; cyc(3); sc_i = 0; cyc(SETTLE);
        chk("R6 short latched", O_FLAG);

        cur_req = "R7";
        dis_i = 1; cyc(SETTLE);
        chk("R7 rising disable no clear", O_FLAG);
        dis_i = 0; cyc(SETTLE);
        chk("R7 falling disable clears", O_FWD);
        sc_i = 1; cyc(SETTLE);
        dis_i = 1; cyc(SETTLE); dis_i = 0; cyc(SETTLE);
        chk("R7 relatch with fault present", O_FLAG);
        sc_i = 0; cyc(SETTLE);
        en_i = 0; cyc(SETTLE); en_i = 1; cyc(SETTLE);
        chk("R7 enable rise clears", O_FWD);

        cur_req = "R8";
        cool_i = 0; ot_i = 1; cyc(SETTLE); ot_i = 0; cyc(SETTLE);
        chk("R6 overtemp latched", O_FLAG);
        dis_i = 1; cyc(SETTLE); dis_i = 0; cyc(SETTLE);
        chk("R8 still hot after clear", O_FLAG);
        cool_i = 1; cyc(SETTLE);
        chk("R8 cooled returns", O_FWD);
        ot_i = 1; cool_i = 0; cyc(SETTLE); ot_i = 0; cool_i = 1; cyc(SETTLE);
        chk("R8 latch holds while cooled", O_FLAG);
        dis_i = 1; cyc(SETTLE); dis_i = 0; cyc(SETTLE);
        chk("R8 cooled before clear goes straight on", O_FWD);

        cyc(5);
        finish_run();
    end

endmodule